// File: doc/BRIEF.md
# Two-Channel Vectored Interrupt Priority Arbiter

This block sits between two interrupt-raising peripherals and one processor. Each peripheral raises a request line. The arbiter combines the requests into a single interrupt line to the processor. It does so only for channels that software has unmasked, and only while software has switched the arbiter on.

When the processor acknowledges the interrupt, the arbiter picks one winner with a fixed priority. It raises that channel's acknowledge and nothing else. It also drives a byte that software wrote for the winning channel. The processor uses this byte as an index into a handler table of up to 256 entries. The winner is frozen for as long as the processor holds its acknowledge, so requests that change in the meantime cannot swap the channel or the byte halfway through the handshake.

Configuration uses a small register port with a two-bit word address, a write strobe and combinational read data.

Top module: `vec_prio_arbiter`

## Requirements
- R1: The configuration space holds four byte registers, each written on the clock edge where `regWe` is high. Address 0 is the channel mask, address 1 is the channel 0 table index, address 2 is the channel 1 table index and address 3 is the enable register. `regRdata` always shows the full current value of the register at `regAddr`, and reading changes nothing.
- R2: After reset all four registers read 0. `irqOut`, `chAck` and `vecOe` are low, and `vecData` is 0.
- R3: Mask bit 0 admits channel 0 and mask bit 1 admits channel 1, so a mask of 0x03 admits both. Only bit 0 of the enable register switches the arbiter on; its other bits are stored and read back but have no effect. `irqOut` is high in exactly the cycles where the arbiter is on and at least one admitted request is high.
- R4: The priority is fixed. When both admitted channels request, channel 0 wins.
- R5: While `intAck` is high, at most one bit of `chAck` is high: the winning channel's bit. With `intAck` low, or with no admitted request, `chAck` is 0.
- R6: While `intAck` is high and a winner exists, `vecOe` is high and `vecData` carries the winner's index register. In every other case `vecOe` is low and `vecData` is 0.
- R7: The winner seen in the first cycle of `intAck` is latched at the end of that cycle. It is held, together with its index, while `intAck` stays high, even if requests change. When `intAck` falls, `chAck` and `vecOe` drop in the same cycle, and the next acknowledge picks a new winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register word address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| chReq | input | 2 | Per-channel interrupt request |
| irqOut | output | 1 | Interrupt line to the processor |
| intAck | input | 1 | Interrupt acknowledge from the processor |
| chAck | output | 2 | Per-channel acknowledge |
| vecData | output | 8 | Table index toward the processor data bus |
| vecOe | output | 1 | Output enable for `vecData` |

## Verification
Register writes take effect at the next rising edge. The bench therefore changes a register at a falling edge and reads it back after the following falling edge. `irqOut`, `chAck`, `vecData` and `vecOe` are combinational in the inputs and the current register state, so they are due in the same cycle as their stimulus. The bench drives these inputs at a falling edge and samples one nanosecond later, well before the next rising edge. The latched winner only matters from the second cycle of an acknowledge onward. The hold checks therefore raise `intAck`, let one rising edge pass, change the requests at the next falling edge and sample again in that cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int CH_NUM  = 2;
  localparam int REG_NUM = 4;
  localparam int ADDR_W  = $clog2(REG_NUM);
  localparam int CH_W    = $clog2(CH_NUM);

  // word addresses of the configuration registers
  typedef enum logic [ADDR_W-1:0] {
    ADDR_MASK = 2'd0,
    ADDR_IDX0 = 2'd1,
    ADDR_IDX1 = 2'd2,
    ADDR_EN   = 2'd3
  } regAddr_e;

  // strobes and live decision passed from control to datapath
  typedef struct packed {
    logic            latchWin;
    logic            dropWin;
    logic            liveHit;
    logic [CH_W-1:0] liveCh;
  } arbStrobe_t;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic [CH_NUM-1:0] chReq,
  input  logic [CH_NUM-1:0] maskBits,
  input  logic              enBit,
  input  logic              intAck,
  input  logic              holdValid,
  output logic              irqOut,
  output arbStrobe_t        strb
);

  logic [CH_NUM-1:0] pending;
  logic [CH_W-1:0]   winCh;

  assign pending = chReq & maskBits & {CH_NUM{enBit}};

  // fixed priority: lowest channel number wins
  always_comb begin
    winCh = '0;
    for (int i = CH_NUM - 1; i >= 0; i--) begin
      if (pending[i]) winCh = CH_W'(i);
    end
  end

  assign irqOut        = |pending;
  assign strb.liveHit  = |pending;
  assign strb.liveCh   = winCh;
  assign strb.latchWin = intAck & ~holdValid;
  assign strb.dropWin  = ~intAck & holdValid;

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              intAck,
  input  arbStrobe_t        strb,
  output logic [CH_NUM-1:0] maskBits,
  output logic              enBit,
  output logic              holdValid,
  output logic [CH_NUM-1:0] chAck,
  output logic [DATA_W-1:0] vecData,
  output logic              vecOe
);

  logic [DATA_W-1:0] cfgReg [REG_NUM];
  logic              holdHit;
  logic [CH_W-1:0]   holdCh;
  logic              curHit;
  logic [CH_W-1:0]   curCh;
  logic [DATA_W-1:0] idxSel;

  // configuration registers, one writer per word
  for (genvar r = 0; r < REG_NUM; r++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgReg[r] <= '0;
      end else if (regWe && (regAddr == ADDR_W'(r))) begin
        cfgReg[r] <= regWdata;
      end
    end
  end

  assign regRdata = cfgReg[regAddr];
  assign maskBits = cfgReg[ADDR_MASK][CH_NUM-1:0];
  assign enBit    = cfgReg[ADDR_EN][0];

  // winner capture for the acknowledge handshake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdHit   <= 1'b0;
      holdCh    <= '0;
    end else if (strb.latchWin) begin
      holdValid <= 1'b1;
      holdHit   <= strb.liveHit;
      holdCh    <= strb.liveCh;
    end else if (strb.dropWin) begin
      holdValid <= 1'b0;
    end
  end

  assign curHit = holdValid ? holdHit : strb.liveHit;
  assign curCh  = holdValid ? holdCh  : strb.liveCh;

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ack
    assign chAck[c] = intAck & curHit & (curCh == CH_W'(c));
  end

  always_comb begin
    idxSel = '0;
    for (int c = 0; c < CH_NUM; c++) begin
      if (curCh == CH_W'(c)) idxSel = cfgReg[int'(ADDR_IDX0) + c];
    end
  end

  assign vecOe   = intAck & curHit;
  assign vecData = vecOe ? idxSel : '0;

endmodule

// File: rtl/vec_prio_arbiter.sv
module vec_prio_arbiter
  import arb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [CH_NUM-1:0] chReq,
  output logic              irqOut,
  input  logic              intAck,
  output logic [CH_NUM-1:0] chAck,
  output logic [DATA_W-1:0] vecData,
  output logic              vecOe
);

  arbStrobe_t        strb;
  logic [CH_NUM-1:0] maskBits;
  logic              enBit;
  logic              holdValid;

  arb_ctrl u_ctrl (
    .chReq    (chReq),
    .maskBits (maskBits),
    .enBit    (enBit),
    .intAck   (intAck),
    .holdValid(holdValid),
    .irqOut   (irqOut),
    .strb     (strb)
  );

  arb_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .intAck   (intAck),
    .strb     (strb),
    .maskBits (maskBits),
    .enBit    (enBit),
    .holdValid(holdValid),
    .chAck    (chAck),
    .vecData  (vecData),
    .vecOe    (vecOe)
  );

endmodule

// File: rtl/arb_checker.sv
module arb_checker (
  input logic       clk,
  input logic       rstN,
  input logic       intAck,
  input logic [1:0] chReq,
  input logic       irqOut,
  input logic [1:0] chAck,
  input logic       vecOe
);

  // R5: never more than one channel acknowledged
  p_ack_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chAck));

  // R5: channel acknowledge only inside a processor acknowledge
  p_ack_needs_inta_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|chAck) |-> intAck);

  // R3: interrupt only with some request present
  p_irq_needs_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|chReq));

  // R6: the index is driven only with an acknowledged channel
  p_vec_oe_r6: assert property (@(posedge clk) disable iff (!rstN)
    vecOe |-> (intAck && (|chAck)));

  // R7: grant frozen while the processor acknowledge stays high
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && $past(intAck)) |-> (chAck == $past(chAck)));

endmodule

bind vec_prio_arbiter arb_checker u_arb_checker (
  .clk   (clk),
  .rstN  (rstN),
  .intAck(intAck),
  .chReq (chReq),
  .irqOut(irqOut),
  .chAck (chAck),
  .vecOe (vecOe)
);

// File: tb/test_vec_prio_arbiter.sv
module test_vec_prio_arbiter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [1:0] chReq = '0;
  logic       irqOut;
  logic       intAck = 1'b0;
  logic [1:0] chAck;
  logic [7:0] vecData;
  logic       vecOe;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  localparam logic [7:0] IDX0 = 8'd13;
  localparam logic [7:0] IDX1 = 8'd17;

  // {mask[1:0], en, req[1:0], expIrq, expAck[1:0]}
  localparam int NVEC = 9;
  localparam logic [7:0] VEC [NVEC] = '{
    8'b11_1_00_0_00,
    8'b11_1_01_1_01,
    8'b11_1_10_1_10,
    8'b11_1_11_1_01,
    8'b10_1_11_1_10,
    8'b01_1_10_0_00,
    8'b11_0_11_0_00,
    8'b00_1_11_0_00,
    8'b10_1_01_0_00
  };

  vec_prio_arbiter i_vec_prio_arbiter (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .chReq(chReq),
    .irqOut(irqOut), .intAck(intAck), .chAck(chAck),
    .vecData(vecData), .vecOe(vecOe)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    check(tag, regRdata, exp);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
  end

  initial begin
    // reset state, R2
    repeat (3) @(negedge clk);
    #1;
    check("R2 irq in reset", irqOut, 0);
    rstN = 1'b1;
    chReq = 2'b11; intAck = 1'b1;
    #1;
    check("R2 irq after reset", irqOut, 0);
    check("R2 chAck after reset", chAck, 0);
    check("R2 vecOe after reset", vecOe, 0);
    check("R2 vecData after reset", vecData, 0);
    @(negedge clk);
    intAck = 1'b0; chReq = 2'b00;
    for (int a = 0; a < 4; a++) regRead(2'(a), 8'h00, "R2 register reset value");

    // register map readback, R1
    regWrite(2'd0, 8'hA5);
    regWrite(2'd1, 8'h3C);
    regWrite(2'd2, 8'hC3);
    regWrite(2'd3, 8'h5A);
    regRead(2'd0, 8'hA5, "R1 mask readback");
    regRead(2'd1, 8'h3C, "R1 idx0 readback");
    regRead(2'd2, 8'hC3, "R1 idx1 readback");
    regRead(2'd3, 8'h5A, "R1 enable readback");
    regRead(2'd1, 8'h3C, "R1 reread no side effect");

    regWrite(2'd1, IDX0);
    regWrite(2'd2, IDX1);

    // vector table: R3 masking/enable, R4 priority, R5 ack, R6 index
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] e;
      logic [7:0] expVec;
      e = VEC[v];
      regWrite(2'd0, {6'b0, e[7:6]});
      regWrite(2'd3, {7'b0, e[5]});
      @(negedge clk);
      chReq = e[4:3];
      #1;
      check($sformatf("R3 irq vector %0d", v), irqOut, e[2]);
      check($sformatf("R5 no ack without intAck vector %0d", v), chAck, 0);
      @(negedge clk);
      intAck = 1'b1;
      #1;
      expVec = (e[1:0] == 2'b01) ? IDX0 : (e[1:0] == 2'b10) ? IDX1 : 8'h00;
      check($sformatf("R4 R5 chAck vector %0d", v), chAck, e[1:0]);
      check($sformatf("R6 vecOe vector %0d", v), vecOe, |e[1:0]);
      check($sformatf("R6 vecData vector %0d", v), vecData, expVec);
      @(negedge clk);
      intAck = 1'b0; chReq = 2'b00;
    end

    // R3: enable with only upper bits set stays off
    regWrite(2'd0, 8'h03);
    regWrite(2'd3, 8'hFE);
    @(negedge clk); chReq = 2'b11; #1;
    check("R3 enable upper bits ignored", irqOut, 0);
    regWrite(2'd3, 8'h01);
    #1;
    check("R3 enable bit0 on", irqOut, 1);

    // R7: hold winner while requests change
    @(negedge clk); chReq = 2'b10; intAck = 1'b1; #1;
    check("R7 first ack ch1", chAck, 2'b10);
    @(negedge clk); chReq = 2'b11; #1;
    check("R7 held ack ch1", chAck, 2'b10);
    check("R7 held index", vecData, IDX1);
    @(negedge clk); chReq = 2'b00; #1;
    check("R7 held with requests gone", chAck, 2'b10);
    @(negedge clk); intAck = 1'b0; chReq = 2'b11; #1;
    check("R7 ack drops with intAck", chAck, 0);
    check("R7 vecOe drops with intAck", vecOe, 0);
    @(negedge clk); intAck = 1'b1; #1;
    check("R7 new winner ch0", chAck, 2'b01);
    check("R7 new index", vecData, IDX0);

    // R7: ack raised with no request stays empty when a request appears
    @(negedge clk); intAck = 1'b0; chReq = 2'b00;
    @(negedge clk); intAck = 1'b1; #1;
    check("R7 empty ack", chAck, 0);
    @(negedge clk); chReq = 2'b01; #1;
    check("R7 empty ack held", chAck, 0);
    check("R7 empty ack no vecOe", vecOe, 0);
    @(negedge clk); intAck = 1'b0; chReq = 2'b00;

    repeat (2) @(negedge clk);
    report();
  end

endmodule